// File: doc/BRIEF.md
# LRU Way Replacement Tracker

This block keeps the least-recently-used ordering of the ways of one cache set, or of a fully-associative cache, and always shows which way should be evicted next. A cache controller uses it with two commands. It reports every tag hit through a usage-update interface: an access strobe, a read/write flag, an invalidate flag and the index of the hit way. It issues a replace strobe when it wants to evict the way that the tracker currently names. A set-associative cache instantiates one tracker per set.

The ordering is held as a list of way indices sorted from least to most recently used. A hit moves the hit way to the most-recent end. An invalidate moves the named way to the least-recent end, so that way is refilled first. A replace consumes the current victim and moves it to the most-recent end, because the controller is about to refill it. The victim output is taken from the registered list. It therefore reflects any update in the cycle after the command.

Top module: `lru_victim_tracker`

## Requirements
- R1: A synchronous reset orders the ways by ascending index, with way 0 least recent. After reset `victim_o` reads 0, and back-to-back replaces then name ways 0, 1, 2 … in turn.
- R2: When `access_i`=0 and `replace_i`=0, no command is issued and the ordering is unchanged. This holds whatever `inval_i` is.
- R3: A hit is `access_i`=1, `inval_i`=0, `replace_i`=0. It makes way `way_i` the most recent. Every way that was more recent than it moves one place toward the least-recent end.
- R4: An invalidate is `access_i`=1, `inval_i`=1, `replace_i`=0. It makes way `way_i` the least recent, so `victim_o` equals that way after the update.
- R5: A replace is `access_i`=0, `inval_i`=0, `replace_i`=1. It evicts the way shown on `victim_o` and makes that way the most recent.
- R6: `write_i` has no effect on the ordering. A read (0) and a write (1) behave the same for both hits and invalidates.
- R7: The combinations `access_i`=1 with `replace_i`=1, and `access_i`=0 with `inval_i`=1 and `replace_i`=1, are ignored and leave the ordering unchanged.
- R8: A hit or invalidate whose `way_i` is not below `WAYS` leaves the ordering unchanged.
- R9: `victim_o` comes from registered state. It shows the effect of a command from the clock edge that takes the command, and it is stable between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| access_i | input | 1 | Usage-update strobe (tag hit this cycle) |
| write_i | input | 1 | Read (0) or write (1) access, has no effect on the ordering |
| inval_i | input | 1 | Invalidate the hit way instead of promoting it |
| way_i | input | IDX_W | Index of the hit way |
| replace_i | input | 1 | Evict the current victim |
| victim_o | output | IDX_W | Way that the next replace will evict |

## Verification
The bench uses five ways, so the 3-bit index can name ways that do not exist. A tracker that did not mask such an index would corrupt its list, and it would show a way number of 5 or more, or lose one. Invalidates of the most recent way and of a way in the middle check that the whole gap shifts. A design that only swapped two entries would then name the wrong victim on later replaces. Conflicting strobe combinations and read-versus-write pairs are applied between known states. A decoder that acted on either would change `victim_o` where the expected value stays put. A reset in the middle of a run followed by a full lap of replaces shows whether reset restores the ascending order, or leaves stale entries that repeat a way.

// File: rtl/lru_victim_tracker.sv
module lru_victim_tracker #(
  parameter int WAYS = 32,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             access_i,
  input  logic             write_i,
  input  logic             inval_i,
  input  logic [IDX_W-1:0] way_i,
  input  logic             replace_i,
  output logic [IDX_W-1:0] victim_o
);

  // order_q[0] is least recently used, order_q[WAYS-1] most recently used
  logic [IDX_W-1:0] order_q [WAYS];
  logic [IDX_W-1:0] order_d [WAYS];
  logic [IDX_W-1:0] key;
  logic [WAYS-1:0]  at, ge, le;
  logic             do_hit, do_inv, do_rep, found, unused_write;

  assign unused_write = write_i;
  assign do_hit = access_i & ~inval_i & ~replace_i;
  assign do_inv = access_i &  inval_i & ~replace_i;
  assign do_rep = ~access_i & ~inval_i & replace_i;
  assign key    = do_rep ? order_q[0] : way_i;
  assign found  = |at;

  for (genvar g = 0; g < WAYS; g++) begin : g_pos
    logic [IDX_W-1:0] up, dn;
    assign at[g] = (order_q[g] == key);
    assign ge[g] = |at[g:0];
    assign le[g] = |at[WAYS-1:g];

    if (g == WAYS - 1) begin : g_top
      assign up = key;
    end else begin : g_mid_up
      assign up = ge[g] ? order_q[g+1] : order_q[g];
    end

    if (g == 0) begin : g_bot
      assign dn = key;
    end else begin : g_mid_dn
      assign dn = le[g] ? order_q[g-1] : order_q[g];
    end

    assign order_d[g] = !found            ? order_q[g] :
                        (do_hit | do_rep) ? up :
                        do_inv            ? dn : order_q[g];

    always_ff @(posedge clk) begin
      if (rst) order_q[g] <= IDX_W'(g);
      else     order_q[g] <= order_d[g];
    end
  end

  assign victim_o = order_q[0];

endmodule

module lru_victim_tracker_chk #(
  parameter int WAYS = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             access_i,
  input logic             inval_i,
  input logic [IDX_W-1:0] way_i,
  input logic             replace_i,
  input logic [IDX_W-1:0] victim_o
);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!access_i && !replace_i) |=> $stable(victim_o));

  a_r3_hit_leaves_lru: assert property (@(posedge clk) disable iff (rst)
    (WAYS > 1 && access_i && !inval_i && !replace_i && int'(way_i) < WAYS)
      |=> victim_o != $past(way_i));

  a_r4_inval_is_victim: assert property (@(posedge clk) disable iff (rst)
    (access_i && inval_i && !replace_i && int'(way_i) < WAYS)
      |=> victim_o == $past(way_i));

  a_r5_replace_advances: assert property (@(posedge clk) disable iff (rst)
    (WAYS > 1 && !access_i && !inval_i && replace_i)
      |=> victim_o != $past(victim_o));

  a_r7_conflict_ignored: assert property (@(posedge clk) disable iff (rst)
    ((access_i && replace_i) || (!access_i && inval_i && replace_i))
      |=> $stable(victim_o));

  a_r8_victim_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(victim_o) < WAYS);

endmodule

bind lru_victim_tracker lru_victim_tracker_chk #(.WAYS(WAYS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .access_i(access_i), .inval_i(inval_i),
  .way_i(way_i), .replace_i(replace_i), .victim_o(victim_o)
);

// File: tb/test_lru_victim_tracker.sv
module test_lru_victim_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 5;
  localparam int IDX_W = 3;
  localparam int NVEC = 17;

  // {req[3:0], access, write, inval, replace, way[2:0], expected victim[2:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {4'd3, 4'b1000, 3'd0, 3'd1},  // R3 hit 0 read
    {4'd6, 4'b1100, 3'd2, 3'd1},  // R6 hit 2 write
    {4'd3, 4'b1000, 3'd1, 3'd3},  // R3 hit 1
    {4'd5, 4'b0001, 3'd0, 3'd4},  // R5 replace evicts 3
    {4'd2, 4'b0000, 3'd3, 3'd4},  // R2 idle
    {4'd4, 4'b1010, 3'd2, 3'd2},  // R4 invalidate 2 read
    {4'd6, 4'b1110, 3'd1, 3'd1},  // R6 invalidate 1 write
    {4'd7, 4'b1001, 3'd4, 3'd1},  // R7 access with replace
    {4'd7, 4'b0011, 3'd2, 3'd1},  // R7 invalidate with replace
    {4'd8, 4'b1000, 3'd6, 3'd1},  // R8 hit out of range
    {4'd3, 4'b1000, 3'd1, 3'd2},  // R3 hit 1
    {4'd5, 4'b0001, 3'd0, 3'd4},  // R5 replace evicts 2
    {4'd5, 4'b0001, 3'd0, 3'd0},  // R5 replace evicts 4
    {4'd4, 4'b1010, 3'd4, 3'd4},  // R4 invalidate the MRU way
    {4'd3, 4'b1100, 3'd4, 3'd0},  // R3 hit on the LRU way
    {4'd2, 4'b0010, 3'd1, 3'd0},  // R2 inval flag alone
    {4'd5, 4'b0001, 3'd0, 3'd3}   // R5 replace evicts 0
  };

  logic clk = 0, rst = 1;
  logic access_i = 0, write_i = 0, inval_i = 0, replace_i = 0;
  logic [IDX_W-1:0] way_i = '0;
  logic [IDX_W-1:0] victim_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lru_victim_tracker #(.WAYS(WAYS)) i_lru_victim_tracker (
    .clk(clk), .rst(rst), .access_i(access_i), .write_i(write_i),
    .inval_i(inval_i), .way_i(way_i), .replace_i(replace_i), .victim_o(victim_o)
  );

  task automatic check(input string req, input logic [IDX_W-1:0] exp);
    tests++;
    if (victim_o !== exp) begin
      fails++;
      $display("FAIL %s: victim=%0d expected=%0d", req, victim_o, exp);
    end
  endtask

  task automatic apply(input logic a, w, i, r, input logic [IDX_W-1:0] wy);
    @(negedge clk);
    access_i = a; write_i = w; inval_i = i; replace_i = r; way_i = wy;
    @(negedge clk);
    access_i = 0; write_i = 0; inval_i = 0; replace_i = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    check("R1", 3'd0);  // R1 reset victim
    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][9], VEC[k][8], VEC[k][7], VEC[k][6], VEC[k][5:3]);
      check($sformatf("R%0d step %0d", VEC[k][13:10], k), VEC[k][2:0]);
    end
    // R9: victim holds between edges with no command
    #(CLK_PERIOD/4);
    check("R9", 3'd3);
    // R1: reset mid-run, then a full lap of replaces
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 after reset", 3'd0);
    for (int k = 1; k <= WAYS; k++) begin
      apply(0, 0, 0, 1, '0);
      check("R1 replace lap", IDX_W'(k % WAYS));
    end
    // R8: invalidate with out-of-range index
    apply(1, 0, 1, 0, 3'd7);
    check("R8 invalidate out of range", 3'd0);
    // R2: several idle cycles
    repeat (3) @(negedge clk);
    check("R2 idle hold", 3'd0);
    done = 1;
  end

  initial begin
    wait (done || $time > 20000 * CLK_PERIOD);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: done=0 expected=1");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule